// File: doc/BRIEF.md
# Kick-Committed Fractional Clock Enable

This block turns a parent clock into a clock-enable pulse train whose average rate is k/32 of the parent, with k between 1 and 32. The ratio is held in a 5-bit field of a 32-bit ratio register as the value 32 - k, so a field of 0 means every cycle and a field of 31 means one cycle in 32. The field's bit position is a parameter. The other bits of that register are plain storage, so software can change the field with a read-modify-write.

Writing the ratio register only stages a value; the output keeps its current rate. Software commits the staged field by writing 1 to bit 31 of a separate control register (the commit flag). The hardware waits for the end of the current 32-cycle pattern window, loads the new ratio there, and clears the commit flag by itself a fixed number of cycles later. Software polls the flag for 0. While the flag is set, writes to the ratio register are dropped. Inside each window the pulses come from a 5-bit phase accumulator, so they are spread evenly and not bunched together.

Top module: `kick_frac_clkgate`

## Requirements
- R1: Once a ratio is active, every 32 consecutive cycles of `clkEn` hold exactly k = 32 - field pulses.
- R2: A field of 0 makes `clkEn` high on every cycle; a field of 31 gives exactly one pulse in 32 cycles.
- R3: The field sits at bits [FIELD_LSB+4:FIELD_LSB] of the ratio register (address 0). All 32 bits written are stored and read back unchanged.
- R4: A write to the control register (address 1) with bit 31 set makes bit 31 read 1 from the next cycle on. A write with bit 31 clear has no effect. Bits 30:0 read 0.
- R5: The commit flag clears by itself no earlier than one cycle after the new ratio loads and no later than 32 + SETTLE_CYCLES cycles after it was set.
- R6: A write to the ratio register while the commit flag reads 1 is dropped.
- R7: A staged field has no effect on `clkEn` until a commit.
- R8: The active ratio changes only at the last cycle of a 32-cycle window.
- R9: After reset the ratio register reads 0, the commit flag reads 0, and `clkEn` runs at full rate.
- R10: With k = 16, `clkEn` never stays high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = ratio register, 1 = control register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| clkEn | output | 1 | Fractional clock-enable pulse |

## Verification
The bench uses the default FIELD_LSB of 8 and SETTLE_CYCLES of 2. The field then sits inside the word, with stored bits on both sides, so the read-back check shows that neighbouring bits survive. With a short settle delay, the commit flag can be caught while it is set: a write dropped during that time is visible, and the flag's self-clear falls within a short poll.

// File: rtl/kfc_pkg.sv
package kfc_pkg;
  localparam int FRAC_W  = 5;
  localparam int WIN_LEN = 1 << FRAC_W;

  typedef struct packed {
    logic              loadActive;
    logic [FRAC_W-1:0] newField;
  } ctrlStrobes_t;
endpackage

// File: rtl/kfc_ctrl.sv
module kfc_ctrl
  import kfc_pkg::*;
#(
  parameter int FIELD_LSB     = 8,
  parameter int SETTLE_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         regAddr,
  input  logic [31:0]  regWrData,
  input  logic         winLast,
  output logic [31:0]  stagedWord,
  output logic         kickPend,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_WIN, ST_SETTLE} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] settleCnt;
  logic wrRatio, wrKick;

  assign kickPend = (state != ST_IDLE);
  assign wrRatio  = regWrEn && !regAddr && !kickPend;
  assign wrKick   = regWrEn && regAddr && regWrData[31];

  always_comb begin
    strobes.loadActive = (state == ST_WAIT_WIN) && winLast;
    strobes.newField   = stagedWord[FIELD_LSB +: FRAC_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedWord <= '0;
    end else if (wrRatio) begin
      stagedWord <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (wrKick) state <= ST_WAIT_WIN;
        ST_WAIT_WIN: if (winLast) begin
          state     <= ST_SETTLE;
          settleCnt <= CNT_W'(SETTLE_CYCLES - 1);
        end
        ST_SETTLE: begin
          if (settleCnt == '0) state <= ST_IDLE;
          else                 settleCnt <= settleCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kfc_datapath.sv
module kfc_datapath
  import kfc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic              winLast,
  output logic [FRAC_W-1:0] activeField,
  output logic              clkEn
);
  logic [FRAC_W-1:0] winCnt;
  logic [FRAC_W-1:0] phaseAcc;
  logic [FRAC_W:0]   kVal;
  logic [FRAC_W:0]   phaseSum;

  assign winLast  = (winCnt == FRAC_W'(WIN_LEN - 1));
  assign kVal     = (FRAC_W+1)'(WIN_LEN) - {1'b0, activeField};
  assign phaseSum = {1'b0, phaseAcc} + kVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt      <= '0;
      phaseAcc    <= '0;
      activeField <= '0;
      clkEn       <= 1'b0;
    end else begin
      winCnt <= winCnt + 1'b1;
      clkEn  <= phaseSum[FRAC_W];
      if (strobes.loadActive) begin
        activeField <= strobes.newField;
        phaseAcc    <= '0;
      end else begin
        phaseAcc    <= phaseSum[FRAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/kick_frac_clkgate.sv
module kick_frac_clkgate
  import kfc_pkg::*;
#(
  parameter int FIELD_LSB     = 8,
  parameter int SETTLE_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        clkEn
);
  ctrlStrobes_t      strobes;
  logic              winLast;
  logic              kickPend;
  logic [31:0]       stagedWord;
  logic [FRAC_W-1:0] activeField;

  kfc_ctrl #(.FIELD_LSB(FIELD_LSB), .SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .winLast(winLast), .stagedWord(stagedWord),
    .kickPend(kickPend), .strobes(strobes)
  );

  kfc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .winLast(winLast),
    .activeField(activeField), .clkEn(clkEn)
  );

  assign regRdData = regAddr ? {kickPend, 31'b0} : stagedWord;
endmodule

// File: rtl/kick_frac_clkgate_chk.sv
module kick_frac_clkgate_chk
  import kfc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regAddr,
  input logic              clkEn,
  input logic              kickPend,
  input logic              winLast,
  input logic [31:0]       stagedWord,
  input logic [FRAC_W-1:0] activeField,
  input ctrlStrobes_t      strobes
);
  AST_STAGED_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (kickPend && regWrEn && !regAddr) |=> $stable(stagedWord)); // R6
  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadActive |-> winLast); // R8
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rstN)
    (activeField == '0) |=> clkEn); // R2
  AST_KICK_NOT_WITH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(kickPend) |-> !$past(strobes.loadActive)); // R5
  AST_LOAD_NEEDS_KICK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadActive |-> kickPend); // R7
endmodule

bind kick_frac_clkgate kick_frac_clkgate_chk chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .clkEn(clkEn),
  .kickPend(kickPend), .winLast(winLast), .stagedWord(stagedWord),
  .activeField(activeField), .strobes(strobes)
);

// File: tb/kick_frac_clkgate_tb_top.sv
`timescale 1ns/1ps
module kick_frac_clkgate_tb_top;
  localparam int FIELD_LSB = 8;
  localparam int NVEC = 8;
  localparam logic [4:0] FIELDS [NVEC] = '{5'd0, 5'd31, 5'd16, 5'd1, 5'd15, 5'd24, 5'd7, 5'd30};
  localparam logic [31:0] OTHER = 32'hA5C3_E07F;

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, regAddr = 1'b0, clkEn;
  logic [31:0] regWrData = '0, regRdData;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kick_frac_clkgate #(.FIELD_LSB(FIELD_LSB), .SETTLE_CYCLES(2)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .clkEn(clkEn)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [31:0] withField(logic [31:0] base, logic [4:0] f);
    logic [31:0] w = base;
    w[FIELD_LSB +: 5] = f;
    return w;
  endfunction

  task automatic waitKickClear(string req);
    logic [31:0] d;
    int n = 0;
    rd(1'b1, d);
    while (d[31] && n < 40) begin
      @(negedge clk); n++;
      rd(1'b1, d);
    end
    check(req, d[31], 0);
  endtask

  task automatic countPulses(output int cnt, output int pairs);
    logic prev = 1'b0;
    cnt = 0; pairs = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (clkEn) cnt++;
      if (clkEn && prev) pairs++;
      prev = clkEn;
    end
  endtask

  initial begin
    logic [31:0] d;
    int cnt, pairs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: reset state
    rd(1'b0, d); check("R9 ratio", d, 0);
    rd(1'b1, d); check("R9 kick", d, 0);
    repeat (4) @(negedge clk);
    countPulses(cnt, pairs); check("R9 full rate", cnt, 32);

    // Vector walk: R1, R2, R3, R5
    for (int v = 0; v < NVEC; v++) begin
      wr(1'b0, withField(OTHER, FIELDS[v]));
      wr(1'b1, 32'h8000_0000);
      waitKickClear("R5 self clear");
      rd(1'b0, d); check("R3 readback", d, withField(OTHER, FIELDS[v]));
      repeat (5) @(negedge clk);
      countPulses(cnt, pairs);
      check((FIELDS[v] == 0 || FIELDS[v] == 31) ? "R2 rate" : "R1 rate", cnt, 32 - FIELDS[v]);
    end

    // R10: k = 16 spread
    wr(1'b0, withField('0, 5'd16));
    wr(1'b1, 32'h8000_0000);
    waitKickClear("R5 self clear");
    repeat (3) @(negedge clk);
    countPulses(cnt, pairs);
    check("R10 count", cnt, 16);
    check("R10 no adjacent", pairs, 0);

    // R7: staged without commit leaves rate alone
    wr(1'b0, withField('0, 5'd0));
    repeat (40) @(negedge clk);
    countPulses(cnt, pairs); check("R7 no commit", cnt, 16);

    // R4: zero write to control has no effect; commit sets flag
    wr(1'b1, 32'h7FFF_FFFF);
    rd(1'b1, d); check("R4 zero write", d, 0);
    wr(1'b0, withField('0, 5'd8));
    wr(1'b1, 32'h8000_0000);
    rd(1'b1, d); check("R4 flag set", d, 32'h8000_0000);
    // R6: write while pending is dropped
    wr(1'b0, withField('0, 5'd3));
    waitKickClear("R5 self clear");
    rd(1'b0, d); check("R6 dropped", d, withField('0, 5'd8));
    repeat (3) @(negedge clk);
    countPulses(cnt, pairs); check("R6 rate", cnt, 24);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule